// File: doc/BRIEF.md
# Byte/Word Shift and Rotate Unit with Carry

This block performs the shift and rotate family of operations on an 8-bit or 16-bit operand in a single clock cycle. It supports logical shifts in both directions, an arithmetic right shift that copies the sign bit, plain rotates in both directions, and rotates that pass through the carry flag. The count is either the constant one or a value taken from a count register. An operation is launched by a one-cycle `go` strobe. The result, the new carry, the parity, sign and zero flags, and the write enables for those flags are registered. They appear on the outputs in the cycle after the strobe.

The write enables tell the surrounding datapath which flags to update. Shifts with a non-zero count update carry, parity, sign and zero. Rotates with a non-zero count update carry only. A zero count, or the reserved opcode, leaves the operand and every flag unchanged. Operand fetch and writeback of the result lie outside the block.

Top module: `srot_unit`

## Requirements
- R1: Opcode 0 (left shift) fills vacated bits with zeros. CF is the last bit pushed out, which is original bit (W-n) for a count n of at most W. For n greater than W, CF is 0.
- R2: Opcode 1 (logical right shift) fills vacated bits with zeros. CF is original bit n-1 for n of at most W. For n greater than W, CF is 0.
- R3: Opcode 2 (arithmetic right shift) fills vacated bits with the original MSB. CF is original bit n-1. When n is at least W, the result is all sign bits, and for n greater than W, CF equals the sign bit.
- R4: Opcodes 3 and 4 (rotate left and rotate right) rotate by n modulo W. CF takes result bit 0 after a left rotate and the result MSB after a right rotate. The carry write enable is set even when n modulo W is 0.
- R5: Opcodes 5 and 6 (rotate left and rotate right through carry) rotate a W+1-bit ring built as {CF, operand} by n modulo (W+1). The new CF is the ring's extra top bit.
- R6: When `use_cnt`=0 the count is 1, and the `cnt` input has no effect. When `use_cnt`=1 the count is `cnt`.
- R7: An effective count of 0 returns the operand unchanged, sets `cf_out` equal to `cf_in`, and clears both write enables.
- R8: A shift with a non-zero count raises `cf_we` and `szp_we`. `pf` is 1 when result bits 7..0 hold an even number of ones. `sf` is the MSB of the selected width. `zf` is 1 when the result is zero.
- R9: A rotate with a non-zero count raises `cf_we` and keeps `szp_we` low.
- R10: With `wide`=0 only operand bits 7..0 take part, and result bits 15..8 are zero.
- R11: Outputs load in the cycle after `go`. Write enables are high only in that cycle, and the result holds while `go` is low. Opcode 7 passes the operand through with both enables low.
- R12: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Launch strobe; inputs are sampled on this cycle |
| op | input | 3 | Operation code (0 SHL, 1 SHR, 2 SAR, 3 ROL, 4 ROR, 5 RCL, 6 RCR, 7 pass) |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| use_cnt | input | 1 | 1 = count from `cnt`, 0 = count of one |
| cnt | input | 5 | Count register value |
| opnd | input | 16 | Operand |
| cf_in | input | 1 | Incoming carry flag |
| res | output | 16 | Result |
| cf_out | output | 1 | New carry flag |
| cf_we | output | 1 | Carry write enable |
| pf | output | 1 | Parity flag of the result low byte |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| szp_we | output | 1 | Write enable for PF, SF and ZF |

## Verification
The assertions check properties that hold on every cycle:
- the enables return low on a cycle without `go`;
- a flag-group write always comes with a carry write;
- rotates never write the flag group;
- byte mode leaves the upper result byte at zero;
- a zero count passes the operand and carry through untouched.

Only the bench's scenarios can show the exact bit patterns:
- which bit ends up in CF at and beyond the width boundary;
- the modulo behaviour of both rotate kinds;
- the sign fill of the arithmetic shift;
- the flag values themselves.

// File: rtl/srot_pkg.sv
package srot_pkg;
  typedef enum logic [2:0] {
    SR_SHL = 3'd0,
    SR_SHR = 3'd1,
    SR_SAR = 3'd2,
    SR_ROL = 3'd3,
    SR_ROR = 3'd4,
    SR_RCL = 3'd5,
    SR_RCR = 3'd6,
    SR_NOP = 3'd7
  } sr_op_e;

  function automatic logic sr_is_rot(sr_op_e o);
    return (o == SR_ROL) || (o == SR_ROR) || (o == SR_RCL) || (o == SR_RCR);
  endfunction
endpackage

// File: rtl/srot_lane.sv
module srot_lane
  import srot_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 5
) (
  input  sr_op_e           op,
  input  logic [CNT_W-1:0] amt,
  input  logic [W-1:0]     din,
  input  logic             cin,
  output logic [W-1:0]     dout,
  output logic             cout
);
  localparam logic [CNT_W-1:0] MOD_W  = CNT_W'(W);
  localparam logic [CNT_W-1:0] MOD_W1 = CNT_W'(W + 1);

  logic [2*W:0]        shl_t;
  logic [W:0]          shr_t;
  logic signed [W:0]   sar_t;
  logic [CNT_W-1:0]    m_w, m_w1;
  logic [2*W-1:0]      rol_t, ror_t;
  logic [W:0]          ring;
  logic [2*W+1:0]      rcl_t, rcr_t;

  // shifts: one spare bit on the exit side captures the last bit out
  assign shl_t = {{(W+1){1'b0}}, din} << amt;
  assign shr_t = {din, 1'b0} >> amt;
  assign sar_t = $signed({din, 1'b0}) >>> amt;

  // rotates: doubled vector, count reduced to the ring length
  assign m_w   = amt % MOD_W;
  assign m_w1  = amt % MOD_W1;
  assign rol_t = {din, din} << m_w;
  assign ror_t = {din, din} >> m_w;
  assign ring  = {cin, din};
  assign rcl_t = {ring, ring} << m_w1;
  assign rcr_t = {ring, ring} >> m_w1;

  always_comb begin
    dout = din;
    cout = cin;
    unique case (op)
      SR_SHL: begin dout = shl_t[W-1:0];       cout = shl_t[W];       end
      SR_SHR: begin dout = shr_t[W:1];         cout = shr_t[0];       end
      SR_SAR: begin dout = sar_t[W:1];         cout = sar_t[0];       end
      SR_ROL: begin dout = rol_t[2*W-1:W];     cout = rol_t[W];       end
      SR_ROR: begin dout = ror_t[W-1:0];       cout = ror_t[W-1];     end
      SR_RCL: begin dout = rcl_t[2*W:W+1];     cout = rcl_t[2*W+1];   end
      SR_RCR: begin dout = rcr_t[W-1:0];       cout = rcr_t[W];       end
      default: begin dout = din;               cout = cin;            end
    endcase
  end
endmodule

// File: rtl/srot_flags.sv
module srot_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         wide,
  output logic         pf,
  output logic         sf,
  output logic         zf
);
  localparam int HW = W / 2;

  assign pf = ~(^val[7:0]);
  assign sf = wide ? val[W-1] : val[HW-1];
  assign zf = (val == '0);
endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic              use_cnt,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cf_in,
  output logic [DATA_W-1:0] res,
  output logic              cf_out,
  output logic              cf_we,
  output logic              pf,
  output logic              sf,
  output logic              zf,
  output logic              szp_we
);
  localparam int HALF_W = DATA_W / 2;

  sr_op_e            op_e;
  logic [CNT_W-1:0]  eff_cnt;
  logic [DATA_W-1:0] lane_res [2];
  logic              lane_cf  [2];
  logic [DATA_W-1:0] src_sel;
  logic [DATA_W-1:0] res_n;
  logic              cf_n, cfwe_n, szpwe_n;
  logic              pf_n, sf_n, zf_n;

  assign op_e    = sr_op_e'(op);
  assign eff_cnt = use_cnt ? cnt : CNT_W'(1);
  assign src_sel = wide ? opnd : {{HALF_W{1'b0}}, opnd[HALF_W-1:0]};

  // one lane per operand width: index 0 byte, index 1 word
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 0) ? HALF_W : DATA_W;
    logic [LW-1:0] l_res;
    logic          l_cf;
    srot_lane #(.W(LW), .CNT_W(CNT_W)) i_lane (
      .op  (op_e),
      .amt (eff_cnt),
      .din (opnd[LW-1:0]),
      .cin (cf_in),
      .dout(l_res),
      .cout(l_cf)
    );
    assign lane_res[g] = DATA_W'(l_res);
    assign lane_cf[g]  = l_cf;
  end

  // next-state selection
  always_comb begin
    if ((eff_cnt == '0) || (op_e == SR_NOP)) begin
      res_n   = src_sel;
      cf_n    = cf_in;
      cfwe_n  = 1'b0;
      szpwe_n = 1'b0;
    end else begin
      res_n   = wide ? lane_res[1] : lane_res[0];
      cf_n    = wide ? lane_cf[1]  : lane_cf[0];
      cfwe_n  = 1'b1;
      szpwe_n = !sr_is_rot(op_e);
    end
  end

  srot_flags #(.W(DATA_W)) i_flags (
    .val (res_n),
    .wide(wide),
    .pf  (pf_n),
    .sf  (sf_n),
    .zf  (zf_n)
  );

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res    <= '0;
      cf_out <= 1'b0;
      pf     <= 1'b0;
      sf     <= 1'b0;
      zf     <= 1'b0;
      cf_we  <= 1'b0;
      szp_we <= 1'b0;
    end else begin
      if (go) begin
        res    <= res_n;
        cf_out <= cf_n;
        pf     <= pf_n;
        sf     <= sf_n;
        zf     <= zf_n;
      end
      cf_we  <= go & cfwe_n;
      szp_we <= go & szpwe_n;
    end
  end

  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!cf_we && !szp_we));

  // R8
  szp_implies_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    szp_we |-> cf_we);

  // R9
  rot_no_szp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op >= 3'd3 && op <= 3'd6) |=> !szp_we);

  // R10
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wide) |=> (res[DATA_W-1:HALF_W] == '0));

  // R7
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wide && use_cnt && cnt == '0) |=>
      (res == $past(opnd) && cf_out == $past(cf_in) && !cf_we && !szp_we));
endmodule

// File: tb/test_srot_unit.sv
module test_srot_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic        wide;
    logic        uc;
    logic [4:0]  cnt;
    logic [15:0] d;
    logic        ci;
    logic [15:0] er;
    logic        ec;
    logic        ecw;
    logic        esw;
    logic        ep;
    logic        es;
    logic        ez;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  // fields: op wide uc cnt d ci | er ec ecw esw ep es ez req
  localparam vec_t VECS [NV] = '{
    '{3'd2, 1'b1, 1'b1, 5'd2,  16'h091A, 1'b0, 16'h0246, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd6, 1'b1, 1'b1, 5'd4,  16'h1234, 1'b0, 16'h8123, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd1, 1'b0, 1'b1, 5'd4,  16'h00B8, 1'b0, 16'h000B, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd0, 1'b0, 1'b0, 5'd0,  16'hFF81, 1'b0, 16'h0002, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{3'd0, 1'b1, 1'b1, 5'd16, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1},  // R1
    '{3'd0, 1'b1, 1'b1, 5'd17, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1},  // R1
    '{3'd1, 1'b1, 1'b1, 5'd20, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
    '{3'd2, 1'b0, 1'b1, 5'd9,  16'h0080, 1'b0, 16'h00FF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd3, 1'b1, 1'b1, 5'd4,  16'h1234, 1'b0, 16'h2341, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd3, 1'b1, 1'b1, 5'd16, 16'h8001, 1'b0, 16'h8001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd4, 1'b0, 1'b1, 5'd9,  16'h0001, 1'b0, 16'h0080, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd5, 1'b0, 1'b1, 5'd9,  16'h0055, 1'b1, 16'h0055, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd5, 1'b0, 1'b1, 5'd1,  16'h0080, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{3'd6, 1'b1, 1'b0, 5'd0,  16'h0001, 1'b1, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd0, 1'b1, 1'b1, 5'd0,  16'hABCD, 1'b1, 16'hABCD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{3'd7, 1'b1, 1'b1, 5'd3,  16'h1357, 1'b0, 16'h1357, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{3'd1, 1'b0, 1'b0, 5'd5,  16'h0003, 1'b0, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{3'd2, 1'b1, 1'b1, 5'd1,  16'h8000, 1'b1, 16'hC000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8}   // R8
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        go;
  logic [2:0]  op;
  logic        wide, use_cnt, cf_in;
  logic [4:0]  cnt;
  logic [15:0] opnd;
  logic [15:0] res;
  logic        cf_out, cf_we, pf, sf, zf, szp_we;
  int          n_run  = 0;
  int          n_fail = 0;
  logic        done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srot_unit i_srot_unit (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .wide(wide),
    .use_cnt(use_cnt), .cnt(cnt), .opnd(opnd), .cf_in(cf_in),
    .res(res), .cf_out(cf_out), .cf_we(cf_we), .pf(pf), .sf(sf),
    .zf(zf), .szp_we(szp_we)
  );

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    go = 1'b1; op = v.op; wide = v.wide; use_cnt = v.uc;
    cnt = v.cnt; opnd = v.d; cf_in = v.ci;
    @(negedge clk);
    go = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; go = 1'b0; op = '0; wide = 1'b0; use_cnt = 1'b0;
    cnt = '0; opnd = '0; cf_in = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check({res, cf_out, cf_we, pf, sf, zf, szp_we} == '0, 12, "reset outputs",
          {10'd0, res, cf_out, cf_we, pf, sf, zf, szp_we}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      check(res == VECS[i].er, int'(VECS[i].req), $sformatf("vec %0d res", i), 32'(res), 32'(VECS[i].er));
      check(cf_out == VECS[i].ec, int'(VECS[i].req), $sformatf("vec %0d cf", i), 32'(cf_out), 32'(VECS[i].ec));
      check(cf_we == VECS[i].ecw && szp_we == VECS[i].esw, int'(VECS[i].req),
            $sformatf("vec %0d enables", i), {30'd0, cf_we, szp_we}, {30'd0, VECS[i].ecw, VECS[i].esw});
      if (VECS[i].esw)
        check({pf, sf, zf} == {VECS[i].ep, VECS[i].es, VECS[i].ez}, 8,
              $sformatf("vec %0d pf/sf/zf", i), {29'd0, pf, sf, zf},
              {29'd0, VECS[i].ep, VECS[i].es, VECS[i].ez});
    end

    // R11 hold: enables drop and result stays without go
    launch(VECS[0]);
    @(negedge clk);
    check(!cf_we && !szp_we, 11, "enables after idle cycle", {30'd0, cf_we, szp_we}, 32'd0);
    check(res == 16'h0246, 11, "result held", 32'(res), 32'h0246);

    // R6 count field ignored with use_cnt=0: same result for two cnt values
    launch('{3'd0, 1'b1, 1'b0, 5'd9, 16'h4001, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6});
    check(res == 16'h8002 && cf_out == 1'b0, 6, "count-one shift cnt ignored",
          {15'd0, cf_out, res}, 32'h8002);

    // R12 reset asserted mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(res == '0 && !cf_out, 12, "reset clears", {15'd0, cf_out, res}, 32'd0);
    rst_n = 1'b1;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule